// File: doc/BRIEF.md
# DDR3 Read-Calibration Pattern Sequencer

This block sits on the controller side of a DDR3 interface. It runs the short command sequence that places the memory in its fixed-pattern read mode, reads the predefined calibration burst a chosen number of times, checks each burst that comes back, and then takes the memory out of the mode. The system starts it with a single-cycle `start` pulse. It reports the result as a one-cycle `done` pulse together with a `pass` flag that stays valid until the next start.

The block drives a registered command bus. The bus carries a 2-bit command code (idle, precharge-all, mode-register write, read), a bank field and an address field. The delays that precede each command come from configuration inputs. The system must hold these inputs steady while `busy` is high. These delays are: precharge to mode write, mode write to first read (the larger of two settings applies), read to read, last read to exit write, and exit write to completion. A configured delay of N makes the next command appear max(N,1) cycles after the one before it.

Host write requests are granted only while the sequencer is idle. From the cycle a start is accepted until completion, `host_wr_grant` stays low and `busy` stays high.

Top module: `mpr_cal_seq`

## Requirements
- R1: A `start` sampled high while idle makes `cmd_o` show precharge-all (code 1) in the next cycle, with `cmd_addr[10]`=1, all other address bits 0 and `cmd_ba`=0; `busy` rises in the same cycle.
- R2: The mode-register write that enters the pattern mode (code 2) appears max(`cfg_trp`,1) cycles after the precharge-all. It has `cmd_ba`=3 and `cmd_addr`=4 (bit 2 set, bits 1:0 zero, all others zero).
- R3: The first read (code 3, `cmd_addr`=0, `cmd_ba`=0) appears max(`cfg_tmrd`,`cfg_tmod`,1) cycles after the entry write. No read is ever issued outside the pattern mode.
- R4: Exactly max(`cfg_num_reads`,1) reads are issued. Each read after the first follows the previous one by max(`cfg_rd_gap`,1) cycles.
- R5: The exit mode-register write (code 2, `cmd_ba`=3, `cmd_addr`=0) appears max(`cfg_tmprr`,1) cycles after the last read.
- R6: `done` is high for exactly one cycle, max(`cfg_tmod`,1) cycles after the exit write. `busy` is low in that cycle.
- R7: In the `done` cycle, `pass` is 1 only if every returned burst matched and the number of bursts returned equals the number of reads issued. `pass` holds until the next accepted start.
- R8: A burst on `rd_burst` (qualified by `rd_valid`) carries beat k in bits [k*8 +: 8]. It matches when even beats are all zeros and odd beats are all ones; any other value is a mismatch.
- R9: `host_wr_grant` is `host_wr_req` delayed by one register while idle. It is 0 from the cycle `busy` rises until `busy` falls, so no write is granted while the pattern mode is active.
- R10: A `start` pulse while `busy` is high is ignored; the running sequence issues the same commands it would have issued without it.
- R11: In every cycle not named above, `cmd_o` is the idle code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run (accepted when idle) |
| cfg_trp | input | 8 | Precharge to entry-write delay, cycles |
| cfg_tmrd | input | 8 | Entry write to first read, first bound |
| cfg_tmod | input | 8 | Entry write to first read, second bound; exit write to done |
| cfg_tmprr | input | 8 | Last read to exit write delay |
| cfg_rd_gap | input | 8 | Minimum spacing between reads |
| cfg_num_reads | input | 4 | Reads per run (0 means 1) |
| host_wr_req | input | 1 | Host asks to issue a write |
| rd_valid | input | 1 | Returned burst valid |
| rd_burst | input | 64 | Returned 8-beat burst, beat 0 in the low byte |
| cmd_o | output | 2 | Command code: 0 idle, 1 precharge-all, 2 mode write, 3 read |
| cmd_ba | output | 3 | Bank field of the command |
| cmd_addr | output | 14 | Address field of the command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Calibration result, valid from done |
| host_wr_grant | output | 1 | Host write allowed |

## Verification
Each command output comes from one register, so the bench logs the cycle of every non-idle command from the pre-edge values. It then compares the distance between consecutive entries against max(N,1) for the configured delay N, starting from the precharge, which is due one cycle after the sampled start. The `done` pulse is logged the same way and is expected max(`cfg_tmod`,1) cycles after the exit write. The bench reads `pass` and `busy` in the half cycle after that and again several cycles later. Bursts come back a fixed three cycles after each read. The last-read delays used in the runs are long enough that every burst is counted before completion, so the `pass` result depends only on burst content and burst count.

// File: rtl/mpr_cal_pkg.sv
package mpr_cal_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_MRS  = 2'd2,
    CMD_RD   = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_RP   = 3'd1,
    ST_WAIT_MODE = 3'd2,
    ST_WAIT_GAP  = 3'd3,
    ST_WAIT_PRR  = 3'd4,
    ST_WAIT_EXIT = 3'd5
  } seq_st_e;

  // address bit that turns precharge into precharge-all
  localparam int PREA_ALL_BIT = 10;
  // address bit that enables the pattern mode in the mode-register payload
  localparam int PAT_EN_BIT   = 2;
  // bank code of the mode register that holds the pattern control
  localparam int PAT_MR_BANK  = 3;

endpackage

// File: rtl/mpr_wait_timer.sv
module mpr_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (len == '0) ? '0 : len - W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/mpr_burst_chk.sv
module mpr_burst_chk #(
  parameter int BEATS = 8,
  parameter int DQ_W  = 8,
  parameter int CNT_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  valid,
  input  logic [BEATS*DQ_W-1:0] burst,
  output logic                  fail,
  output logic [CNT_W-1:0]      rx_cnt
);
  localparam int BURST_W = BEATS * DQ_W;

  logic [BURST_W-1:0] exp_pat;

  generate
    for (genvar k = 0; k < BEATS; k++) begin : g_beat
      if (k % 2 == 1) begin : g_odd
        assign exp_pat[k*DQ_W +: DQ_W] = {DQ_W{1'b1}};
      end else begin : g_even
        assign exp_pat[k*DQ_W +: DQ_W] = {DQ_W{1'b0}};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail   <= 1'b0;
      rx_cnt <= '0;
    end else if (valid) begin
      if (burst != exp_pat) fail <= 1'b1;
      if (rx_cnt != {CNT_W{1'b1}}) rx_cnt <= rx_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mpr_seq_fsm.sv
module mpr_seq_fsm
  import mpr_cal_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NR_W   = 4,
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_trp,
  input  logic [CNT_W-1:0]  cfg_tmrd,
  input  logic [CNT_W-1:0]  cfg_tmod,
  input  logic [CNT_W-1:0]  cfg_tmprr,
  input  logic [CNT_W-1:0]  cfg_rd_gap,
  input  logic [NR_W-1:0]   cfg_num_reads,
  input  logic              host_wr_req,
  input  logic              tmr_expired,
  input  logic              chk_fail,
  input  logic [NR_W:0]     chk_rx_cnt,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_len,
  output logic              chk_clr,
  output logic [1:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              wr_grant
);
  seq_st_e           st, st_n;
  cmd_e              cmd_q, cmd_n;
  logic [ADDR_W-1:0] addr_n;
  logic [BA_W-1:0]   ba_n;
  logic [NR_W-1:0]   rd_left, rd_left_n;
  logic [NR_W-1:0]   rd_total, rd_total_n;
  logic              done_n, pass_n;
  logic [CNT_W-1:0]  mode_wait;

  assign mode_wait = (cfg_tmrd > cfg_tmod) ? cfg_tmrd : cfg_tmod;

  always_comb begin
    st_n       = st;
    cmd_n      = CMD_NOP;
    addr_n     = '0;
    ba_n       = '0;
    tmr_load   = 1'b0;
    tmr_len    = '0;
    chk_clr    = 1'b0;
    rd_left_n  = rd_left;
    rd_total_n = rd_total;
    done_n     = 1'b0;
    pass_n     = pass;
    case (st)
      ST_IDLE: begin
        if (start) begin
          cmd_n                = CMD_PREA;
          addr_n[PREA_ALL_BIT] = 1'b1;
          tmr_load             = 1'b1;
          tmr_len              = cfg_trp;
          chk_clr              = 1'b1;
          rd_left_n            = (cfg_num_reads == '0) ? NR_W'(1) : cfg_num_reads;
          rd_total_n           = rd_left_n;
          pass_n               = 1'b0;
          st_n                 = ST_WAIT_RP;
        end
      end
      ST_WAIT_RP: begin
        if (tmr_expired) begin
          cmd_n              = CMD_MRS;
          ba_n               = BA_W'(PAT_MR_BANK);
          addr_n[PAT_EN_BIT] = 1'b1;
          tmr_load           = 1'b1;
          tmr_len            = mode_wait;
          st_n               = ST_WAIT_MODE;
        end
      end
      ST_WAIT_MODE, ST_WAIT_GAP: begin
        if (tmr_expired) begin
          cmd_n     = CMD_RD;
          tmr_load  = 1'b1;
          rd_left_n = rd_left - NR_W'(1);
          if (rd_left == NR_W'(1)) begin
            tmr_len = cfg_tmprr;
            st_n    = ST_WAIT_PRR;
          end else begin
            tmr_len = cfg_rd_gap;
            st_n    = ST_WAIT_GAP;
          end
        end
      end
      ST_WAIT_PRR: begin
        if (tmr_expired) begin
          cmd_n    = CMD_MRS;
          ba_n     = BA_W'(PAT_MR_BANK);
          tmr_load = 1'b1;
          tmr_len  = cfg_tmod;
          st_n     = ST_WAIT_EXIT;
        end
      end
      ST_WAIT_EXIT: begin
        if (tmr_expired) begin
          done_n = 1'b1;
          pass_n = !chk_fail && (chk_rx_cnt == {1'b0, rd_total});
          st_n   = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cmd_q    <= CMD_NOP;
      addr     <= '0;
      ba       <= '0;
      rd_left  <= '0;
      rd_total <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      pass     <= 1'b0;
      wr_grant <= 1'b0;
    end else begin
      st       <= st_n;
      cmd_q    <= cmd_n;
      addr     <= addr_n;
      ba       <= ba_n;
      rd_left  <= rd_left_n;
      rd_total <= rd_total_n;
      busy     <= (st_n != ST_IDLE);
      done     <= done_n;
      pass     <= pass_n;
      wr_grant <= host_wr_req && (st_n == ST_IDLE);
    end
  end

  assign cmd = cmd_q;
endmodule

// File: rtl/mpr_cal_seq.sv
module mpr_cal_seq #(
  parameter int CNT_W  = 8,
  parameter int NR_W   = 4,
  parameter int BEATS  = 8,
  parameter int DQ_W   = 8,
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [CNT_W-1:0]      cfg_trp,
  input  logic [CNT_W-1:0]      cfg_tmrd,
  input  logic [CNT_W-1:0]      cfg_tmod,
  input  logic [CNT_W-1:0]      cfg_tmprr,
  input  logic [CNT_W-1:0]      cfg_rd_gap,
  input  logic [NR_W-1:0]       cfg_num_reads,
  input  logic                  host_wr_req,
  input  logic                  rd_valid,
  input  logic [BEATS*DQ_W-1:0] rd_burst,
  output logic [1:0]            cmd_o,
  output logic [BA_W-1:0]       cmd_ba,
  output logic [ADDR_W-1:0]     cmd_addr,
  output logic                  busy,
  output logic                  done,
  output logic                  pass,
  output logic                  host_wr_grant
);
  localparam int RX_W = NR_W + 1;

  logic             tmr_load, tmr_expired, chk_clr, chk_fail;
  logic [CNT_W-1:0] tmr_len;
  logic [RX_W-1:0]  chk_rx_cnt;

  mpr_wait_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_expired)
  );

  mpr_burst_chk #(.BEATS(BEATS), .DQ_W(DQ_W), .CNT_W(RX_W)) u_chk_burst (
    .clk    (clk),
    .rst    (rst),
    .clr    (chk_clr),
    .valid  (rd_valid),
    .burst  (rd_burst),
    .fail   (chk_fail),
    .rx_cnt (chk_rx_cnt)
  );

  mpr_seq_fsm #(.CNT_W(CNT_W), .NR_W(NR_W), .ADDR_W(ADDR_W), .BA_W(BA_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .cfg_trp       (cfg_trp),
    .cfg_tmrd      (cfg_tmrd),
    .cfg_tmod      (cfg_tmod),
    .cfg_tmprr     (cfg_tmprr),
    .cfg_rd_gap    (cfg_rd_gap),
    .cfg_num_reads (cfg_num_reads),
    .host_wr_req   (host_wr_req),
    .tmr_expired   (tmr_expired),
    .chk_fail      (chk_fail),
    .chk_rx_cnt    (chk_rx_cnt),
    .tmr_load      (tmr_load),
    .tmr_len       (tmr_len),
    .chk_clr       (chk_clr),
    .cmd           (cmd_o),
    .ba            (cmd_ba),
    .addr          (cmd_addr),
    .busy          (busy),
    .done          (done),
    .pass          (pass),
    .wr_grant      (host_wr_grant)
  );
endmodule

// File: rtl/mpr_cal_seq_chk.sv
module mpr_cal_seq_chk
  import mpr_cal_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  cfg_trp,
  input logic [CNT_W-1:0]  cfg_tmrd,
  input logic [CNT_W-1:0]  cfg_tmod,
  input logic [CNT_W-1:0]  cfg_tmprr,
  input logic [CNT_W-1:0]  cfg_rd_gap,
  input logic [1:0]        cmd_o,
  input logic [BA_W-1:0]   cmd_ba,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              busy,
  input logic              done,
  input logic              host_wr_grant
);
  logic        mode_on;
  logic [1:0]  last_cmd;
  logic [15:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_on  <= 1'b0;
      last_cmd <= 2'd0;
      gap_cnt  <= '0;
    end else begin
      if (cmd_o != 2'(CMD_NOP)) begin
        last_cmd <= cmd_o;
        gap_cnt  <= 16'd1;
      end else if (gap_cnt != 16'hFFFF) begin
        gap_cnt <= gap_cnt + 16'd1;
      end
      if (cmd_o == 2'(CMD_MRS)) mode_on <= cmd_addr[PAT_EN_BIT];
    end
  end

  // R2
  entry_after_prea_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 2'(CMD_MRS) && last_cmd == 2'(CMD_PREA)) |->
      (32'(gap_cnt) >= 32'(cfg_trp) && cmd_addr[PAT_EN_BIT] && cmd_ba == BA_W'(PAT_MR_BANK)));

  // R3
  first_read_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 2'(CMD_RD) && last_cmd == 2'(CMD_MRS)) |->
      (32'(gap_cnt) >= 32'(cfg_tmrd) && 32'(gap_cnt) >= 32'(cfg_tmod)));

  // R3
  read_in_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 2'(CMD_RD)) |-> mode_on);

  // R4
  read_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 2'(CMD_RD) && last_cmd == 2'(CMD_RD)) |-> 32'(gap_cnt) >= 32'(cfg_rd_gap));

  // R5
  exit_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 2'(CMD_MRS) && last_cmd == 2'(CMD_RD)) |->
      (32'(gap_cnt) >= 32'(cfg_tmprr) && cmd_addr == '0));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  no_write_in_mode_chk: assert property (@(posedge clk) disable iff (rst)
    mode_on |-> !host_wr_grant);
endmodule

bind mpr_cal_seq mpr_cal_seq_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BA_W(BA_W)) u_seq_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_trp       (cfg_trp),
  .cfg_tmrd      (cfg_tmrd),
  .cfg_tmod      (cfg_tmod),
  .cfg_tmprr     (cfg_tmprr),
  .cfg_rd_gap    (cfg_rd_gap),
  .cmd_o         (cmd_o),
  .cmd_ba        (cmd_ba),
  .cmd_addr      (cmd_addr),
  .busy          (busy),
  .done          (done),
  .host_wr_grant (host_wr_grant)
);

// File: tb/sim_mpr_cal_seq.sv
`timescale 1ns/1ps
module sim_mpr_cal_seq;
  localparam int LAT = 3;
  localparam logic [1:0] B_NOP = 2'd0, B_PREA = 2'd1, B_MRS = 2'd2, B_RD = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  cfg_trp = '0, cfg_tmrd = '0, cfg_tmod = '0, cfg_tmprr = '0, cfg_rd_gap = '0;
  logic [3:0]  cfg_num_reads = '0;
  logic        host_wr_req = 1'b0;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_burst = '0;
  logic [1:0]  cmd_o;
  logic [2:0]  cmd_ba;
  logic [13:0] cmd_addr;
  logic        busy, done, pass, host_wr_grant;

  mpr_cal_seq u0 (
    .clk(clk), .rst(rst), .start(start),
    .cfg_trp(cfg_trp), .cfg_tmrd(cfg_tmrd), .cfg_tmod(cfg_tmod),
    .cfg_tmprr(cfg_tmprr), .cfg_rd_gap(cfg_rd_gap), .cfg_num_reads(cfg_num_reads),
    .host_wr_req(host_wr_req), .rd_valid(rd_valid), .rd_burst(rd_burst),
    .cmd_o(cmd_o), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
    .busy(busy), .done(done), .pass(pass), .host_wr_grant(host_wr_grant)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // command log built from pre-edge values
  int cyc = 0, log_n = 0, start_cyc = -1, done_cyc = -1, done_cnt = 0;
  int grant_busy = 0, grant_done = 0;
  int log_code [0:63];
  int log_cyc  [0:63];
  int log_addr [0:63];
  int log_ba   [0:63];

  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      if (start && !busy) start_cyc = cyc;
      if (cmd_o != B_NOP && log_n < 64) begin
        log_code[log_n] = int'(cmd_o);
        log_cyc[log_n]  = cyc;
        log_addr[log_n] = int'(cmd_addr);
        log_ba[log_n]   = int'(cmd_ba);
        log_n++;
      end
      if (done) begin
        done_cyc   = cyc;
        done_cnt++;
        grant_done = int'(host_wr_grant);
      end
      if (busy && host_wr_grant) grant_busy++;
    end
  end

  // burst responder
  int rd_seen = 0, drop_idx = -1, cor_idx = -1, cor_mode = 0;
  bit pv [0:LAT];
  int pi [0:LAT];
  initial for (int i = 0; i <= LAT; i++) begin pv[i] = 1'b0; pi[i] = 0; end

  function automatic logic [63:0] good_burst();
    logic [63:0] b;
    for (int k = 0; k < 8; k++) b[k*8 +: 8] = (k % 2 == 1) ? 8'hFF : 8'h00;
    return b;
  endfunction

  always @(negedge clk) begin
    for (int i = LAT; i > 0; i--) begin pv[i] = pv[i-1]; pi[i] = pi[i-1]; end
    pv[0] = (cmd_o == B_RD);
    pi[0] = rd_seen;
    if (cmd_o == B_RD) rd_seen++;
    rd_valid = pv[LAT] && (pi[LAT] != drop_idx);
    rd_burst = good_burst();
    if (pi[LAT] == cor_idx) rd_burst = (cor_mode == 0) ? (rd_burst ^ 64'h1) : ~rd_burst;
  end

  function automatic int mx1(input int a);
    return (a < 1) ? 1 : a;
  endfunction

  task automatic run_seq(input int trp, input int tmrd, input int tmod, input int tmprr,
                         input int gap, input int nr, input bit mid_start, input bit exp_pass);
    int eff, w, last;
    @(negedge clk);
    cfg_trp = 8'(trp); cfg_tmrd = 8'(tmrd); cfg_tmod = 8'(tmod);
    cfg_tmprr = 8'(tmprr); cfg_rd_gap = 8'(gap); cfg_num_reads = 4'(nr);
    rd_seen = 0; log_n = 0; start_cyc = -1; done_cyc = -1; done_cnt = 0; grant_busy = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (done_cyc < 0 && w < 4000) begin @(negedge clk); w++; end
    check("R6", "done seen", int'(done_cyc >= 0), 1);
    if (done_cyc < 0) return;
    check("R6", "busy at done+1/2", int'(busy), 0);
    check("R7", "pass at done", int'(pass), int'(exp_pass));
    eff = (nr == 0) ? 1 : nr;
    check("R10", "command count", log_n, 3 + eff);
    if (log_n != 3 + eff) return;
    check("R1", "prea code", log_code[0], B_PREA);
    check("R1", "prea cycle", log_cyc[0] - start_cyc, 1);
    check("R1", "prea addr", log_addr[0], 1024);
    check("R1", "prea bank", log_ba[0], 0);
    check("R2", "entry code", log_code[1], B_MRS);
    check("R2", "entry addr", log_addr[1], 4);
    check("R2", "entry bank", log_ba[1], 3);
    check("R2", "entry delay", log_cyc[1] - log_cyc[0], mx1(trp));
    for (int i = 0; i < eff; i++) begin
      check("R4", "read code", log_code[2+i], B_RD);
      check("R3", "read addr", log_addr[2+i], 0);
      if (i == 0) check("R3", "first read delay", log_cyc[2] - log_cyc[1], mx1((tmrd > tmod) ? tmrd : tmod));
      else        check("R4", "read spacing", log_cyc[2+i] - log_cyc[1+i], mx1(gap));
    end
    last = 2 + eff;
    check("R5", "exit code", log_code[last], B_MRS);
    check("R5", "exit addr", log_addr[last], 0);
    check("R5", "exit bank", log_ba[last], 3);
    check("R5", "exit delay", log_cyc[last] - log_cyc[last-1], mx1(tmprr));
    check("R6", "done delay", done_cyc - log_cyc[last], mx1(tmod));
    repeat (4) @(negedge clk);
    check("R6", "done pulses", done_cnt, 1);
    check("R7", "pass held", int'(pass), int'(exp_pass));
    check("R11", "idle after run", int'(cmd_o), B_NOP);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R11", "reset cmd", int'(cmd_o), B_NOP);
    check("R6", "reset busy", int'(busy), 0);
    check("R6", "reset done", int'(done), 0);
    check("R7", "reset pass", int'(pass), 0);
    check("R9", "reset grant", int'(host_wr_grant), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_basic();
    drop_idx = -1; cor_idx = -1;
    run_seq(3, 4, 6, 8, 4, 4, 1'b0, 1'b1);
  endtask

  task automatic t_minimal_delays();
    drop_idx = -1; cor_idx = -1;
    run_seq(0, 0, 0, 6, 0, 0, 1'b0, 1'b1);
  endtask

  task automatic t_back_to_back();
    drop_idx = -1; cor_idx = -1;
    run_seq(2, 7, 5, 6, 1, 8, 1'b0, 1'b1);
  endtask

  task automatic t_bit_error();
    drop_idx = -1; cor_idx = 2; cor_mode = 0;   // R8 single bit in beat 0
    run_seq(1, 2, 3, 6, 2, 4, 1'b0, 1'b0);
  endtask

  task automatic t_inverted_pattern();
    drop_idx = -1; cor_idx = 0; cor_mode = 1;   // R8 beats in wrong polarity
    run_seq(1, 2, 3, 6, 2, 3, 1'b0, 1'b0);
    cor_idx = -1;
    run_seq(1, 2, 3, 6, 2, 3, 1'b0, 1'b1);      // R7 pass recovers on a clean run
  endtask

  task automatic t_missing_burst();
    drop_idx = 1; cor_idx = -1;                 // R7 count mismatch
    run_seq(1, 1, 1, 6, 3, 2, 1'b0, 1'b0);
    drop_idx = -1;
  endtask

  task automatic t_restart_ignored();
    drop_idx = -1; cor_idx = -1;                // R10
    run_seq(4, 3, 3, 7, 2, 3, 1'b1, 1'b1);
  endtask

  task automatic t_write_lockout();
    drop_idx = -1; cor_idx = -1;
    @(negedge clk); host_wr_req = 1'b1;
    @(negedge clk);
    check("R9", "grant while idle", int'(host_wr_grant), 1);
    run_seq(2, 3, 4, 6, 2, 2, 1'b0, 1'b1);
    check("R9", "grants while busy", grant_busy, 0);
    check("R9", "grant at done", grant_done, 1);
    host_wr_req = 1'b0;
    @(negedge clk);
    check("R9", "grant follows drop", int'(host_wr_grant), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_minimal_delays();
    t_back_to_back();
    t_bit_error();
    t_inverted_pattern();
    t_missing_burst();
    t_restart_ignored();
    t_write_lockout();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule